// File: doc/BRIEF.md
# Command-Decoding SPI Register Slave

This block is the device end of a byte-wide SPI link into the control register file of a small radio transceiver. Each chip-select frame opens with a command byte. While that byte shifts in, the block shifts its status byte out. The command then decides what the following bytes do. They can read or write one register. They can fill or return one of the multi-byte address registers, least-significant byte first, up to the configured address width. A command can also raise a one-cycle flush strobe toward the transmit or receive payload buffer, or return the length of the payload at the head of the receive buffer.

The SPI pins run in mode 0 and are oversampled in the block's own clock domain. Event pulses from the radio core set the three interrupt flags in the status byte. Software clears a flag by writing a 1 to its bit. The receive pipe number, the transmit-full level and the head payload length come in as plain inputs.

Top module: `spi_cmd_regslave`

## Requirements
- R1: Frames are SPI mode 0. MISO carries the first bit of the frame once chip select falls and changes only after a falling SCK edge. MOSI is sampled on rising SCK edges. Bytes travel MSB first.
- R2: The first byte on MISO in every frame is the status byte. Command 0xFF and any command not named in these requirements return 0x00 in every later byte and change no register.
- R3: Status byte layout, MSB to LSB: bit 7 = 0, bit 6 = receive-ready flag, bit 5 = transmit-done flag, bit 4 = max-retry flag, bits 3:1 = receive pipe number input, bit 0 = transmit-full input. Register address 0x07 reads back this byte.
- R4: Command 0b000a_aaaa reads register aaaaa. Its bytes appear on MISO from the byte after the command onward. Bytes past the register width return 0x00.
- R5: Command 0b001a_aaaa writes register aaaaa from the bytes after the command. Bytes past the register width are dropped and touch no neighbouring register.
- R6: Writing address 0x07 clears each of flag bits 6:4 written as 1 and leaves those written as 0. An event pulse in the same cycle as the clearing write wins, and the flag stays set.
- R7: Bits 1:0 of register 0x03 select the address width: 1, 2 and 3 give 3, 4 and 5 bytes, and 0 gives 3 bytes. It resets to 0x03.
- R8: Registers 0x0A, 0x0B and 0x10 hold up to 5 bytes. They are read and written least-significant byte first, for the configured width only. Stored bytes past a narrower width are kept.
- R9: Registers 0x0C to 0x0F hold one byte each.
- R10: Command 0xE1 pulses flush_tx and 0xE2 pulses flush_rx for one cycle, the cycle after the command byte completes. Neither changes any register.
- R11: Command 0x60 returns rx_head_len in the byte after the command, and 0x00 after that.
- R12: If chip select rises in the middle of a byte, that partial byte is dropped, with no write and no strobe.
- R13: After reset all flags and registers are zero except register 0x03, and MISO is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, much faster than SCK |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | SPI serial clock, idles low |
| spi_mosi | input | 1 | Serial data from the controller |
| spi_cs_n | input | 1 | Active-low chip select, one frame per low period |
| spi_miso | output | 1 | Serial data to the controller, low while deselected |
| evt_rx_ready | input | 1 | Pulse that sets the receive-ready flag |
| evt_tx_done | input | 1 | Pulse that sets the transmit-done flag |
| evt_max_retry | input | 1 | Pulse that sets the max-retry flag |
| rx_pipe_num | input | 3 | Pipe number of the pending receive payload |
| tx_buf_full | input | 1 | Transmit buffer full level |
| rx_head_len | input | 8 | Length of the head receive payload |
| flush_tx | output | 1 | One-cycle transmit buffer flush strobe |
| flush_rx | output | 1 | One-cycle receive buffer flush strobe |

## Verification
The SPI inputs pass through two synchronizer flops and an edge detector. A new MISO bit therefore appears on the third clock edge after SCK falls, and a flush strobe is high during the third clock after the final rising SCK edge of its command. The bench holds each SCK phase for eight clocks and samples MISO just before it raises SCK, well after that three-cycle delay. For each completed flush command it queues the due cycle as the drive cycle plus three, and it compares both strobes against that queue on every falling clock edge. A behavioural model of the register contents, kept in the bench, supplies the expected value of every byte.

// File: rtl/spi_cmdreg_pkg.sv
package spi_cmdreg_pkg;
  localparam int BYTE_W         = 8;
  localparam int ADDR_W         = 5;
  localparam int REG_COUNT      = 1 << ADDR_W;
  localparam int ADDR_BYTES_MAX = 5;
  localparam int IDX_W          = $clog2(ADDR_BYTES_MAX + 1);
  localparam int NUM_WIDE       = 3;
  localparam int WIDE_ID_W      = $clog2(NUM_WIDE);

  localparam logic [ADDR_W-1:0] REG_AWIDTH = 5'h03;
  localparam logic [ADDR_W-1:0] REG_STATUS = 5'h07;
  localparam logic [ADDR_W-1:0] WIDE_ADDR [NUM_WIDE] = '{5'h0A, 5'h0B, 5'h10};

  localparam logic [BYTE_W-1:0] OP_FLUSH_TX = 8'hE1;
  localparam logic [BYTE_W-1:0] OP_FLUSH_RX = 8'hE2;
  localparam logic [BYTE_W-1:0] OP_RXLEN    = 8'h60;

  typedef enum logic [1:0] {
    ACT_NONE,
    ACT_READ,
    ACT_WRITE,
    ACT_RXLEN
  } act_e;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic mosi,
  input  logic cs_n,
  output logic rst_q_n,
  output logic sel,
  output logic mosi_s,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_fall
);
  localparam logic [2:0] IDLE_VEC = 3'b001;  // {sck, mosi, cs_n}

  logic [STAGES-1:0] rst_pipe;
  logic [2:0]        pin_q [STAGES];
  logic              sck_d, cs_d;

  // Reset asserts at once and releases after STAGES clock edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[STAGES-2:0], 1'b1};
  end
  assign rst_q_n = rst_pipe[STAGES-1];

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) pin_q[0] <= IDLE_VEC;
    else          pin_q[0] <= {sck, mosi, cs_n};
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_q_n) begin
      if (!rst_q_n) pin_q[g] <= IDLE_VEC;
      else          pin_q[g] <= pin_q[g-1];
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      sck_d <= 1'b0;
      cs_d  <= 1'b1;
    end else begin
      sck_d <= pin_q[STAGES-1][2];
      cs_d  <= pin_q[STAGES-1][0];
    end
  end

  assign mosi_s   = pin_q[STAGES-1][1];
  assign sel      = ~pin_q[STAGES-1][0];
  assign sck_rise =  pin_q[STAGES-1][2] & ~sck_d;
  assign sck_fall = ~pin_q[STAGES-1][2] &  sck_d;
  assign cs_fall  = ~pin_q[STAGES-1][0] &  cs_d;
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
  import spi_cmdreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic              cs_fall,
  input  logic              mosi_s,
  input  logic [BYTE_W-1:0] first_byte,
  input  logic [BYTE_W-1:0] next_byte,
  output logic              byte_done,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              miso
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  logic [CNT_W-1:0]  bit_q, bit_d;
  logic [BYTE_W-2:0] rx_q, rx_d;
  logic [BYTE_W-1:0] tx_q, tx_d;

  assign byte_done = sel & sck_rise & (bit_q == LAST_BIT);
  assign rx_byte   = {rx_q, mosi_s};
  assign miso      = sel & tx_q[BYTE_W-1];

  always_comb begin
    bit_d = bit_q;
    rx_d  = rx_q;
    tx_d  = tx_q;
    if (!sel) begin
      // Deselected: any partial byte is dropped here.
      bit_d = '0;
      tx_d  = '0;
    end else if (cs_fall) begin
      bit_d = '0;
      tx_d  = first_byte;
    end else begin
      if (sck_rise) begin
        bit_d = bit_q + 1'b1;
        rx_d  = {rx_q[BYTE_W-3:0], mosi_s};
      end
      if (sck_fall) begin
        tx_d = (bit_q == '0) ? next_byte : {tx_q[BYTE_W-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q <= '0;
      rx_q  <= '0;
      tx_q  <= '0;
    end else begin
      bit_q <= bit_d;
      rx_q  <= rx_d;
      tx_q  <= tx_d;
    end
  end
endmodule

// File: rtl/spi_cmd_regfile.sv
module spi_cmd_regfile
  import spi_cmdreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              byte_done,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              evt_rx_ready,
  input  logic              evt_tx_done,
  input  logic              evt_max_retry,
  input  logic [2:0]        rx_pipe_num,
  input  logic              tx_buf_full,
  input  logic [BYTE_W-1:0] rx_head_len,
  output logic [BYTE_W-1:0] status_byte,
  output logic [BYTE_W-1:0] next_byte,
  output logic              flush_tx,
  output logic              flush_rx
);
  localparam logic [IDX_W-1:0] IDX_MAX = IDX_W'(ADDR_BYTES_MAX);

  logic              have_cmd_q, have_cmd_d;
  act_e              act_q, act_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [2:0]        flags_q, flags_d;   // {rx_ready, tx_done, max_retry}
  logic              ftx_d, frx_d;
  logic [BYTE_W-1:0] regs_q [REG_COUNT];
  logic [BYTE_W-1:0] regs_d [REG_COUNT];
  logic [BYTE_W-1:0] wide_q [NUM_WIDE][ADDR_BYTES_MAX];
  logic [BYTE_W-1:0] wide_d [NUM_WIDE][ADDR_BYTES_MAX];

  logic [NUM_WIDE-1:0]  wide_hits;
  logic                 wide_hit;
  logic [WIDE_ID_W-1:0] wide_id;
  logic [IDX_W-1:0]     aw_len, cur_len;
  logic [BYTE_W-1:0]    rd_byte;

  for (genvar g = 0; g < NUM_WIDE; g++) begin : g_wide_match
    assign wide_hits[g] = (addr_q == WIDE_ADDR[g]);
  end

  always_comb begin
    wide_id = '0;
    for (int i = 0; i < NUM_WIDE; i++)
      if (wide_hits[i]) wide_id = WIDE_ID_W'(i);
  end
  assign wide_hit = |wide_hits;

  always_comb begin
    unique case (regs_q[REG_AWIDTH][1:0])
      2'd2:    aw_len = IDX_W'(4);
      2'd3:    aw_len = IDX_W'(5);
      default: aw_len = IDX_W'(3);
    endcase
  end
  assign cur_len     = wide_hit ? aw_len : IDX_W'(1);
  assign status_byte = {1'b0, flags_q, rx_pipe_num, tx_buf_full};

  // Byte offered for the next byte slot of the frame.
  always_comb begin
    rd_byte = '0;
    if (idx_q < cur_len) begin
      if (wide_hit)                  rd_byte = wide_q[wide_id][idx_q];
      else if (addr_q == REG_STATUS) rd_byte = status_byte;
      else                           rd_byte = regs_q[addr_q];
    end
    unique case (act_q)
      ACT_READ:  next_byte = rd_byte;
      ACT_RXLEN: next_byte = (idx_q == '0) ? rx_head_len : '0;
      default:   next_byte = '0;
    endcase
  end

  always_comb begin
    have_cmd_d = have_cmd_q;
    act_d      = act_q;
    addr_d     = addr_q;
    idx_d      = idx_q;
    flags_d    = flags_q;
    regs_d     = regs_q;
    wide_d     = wide_q;
    ftx_d      = 1'b0;
    frx_d      = 1'b0;
    if (frame_start) begin
      have_cmd_d = 1'b0;
      act_d      = ACT_NONE;
      idx_d      = '0;
    end else if (byte_done) begin
      if (!have_cmd_q) begin
        have_cmd_d = 1'b1;
        idx_d      = '0;
        addr_d     = rx_byte[ADDR_W-1:0];
        if (rx_byte[7:5] == 3'b000)      act_d = ACT_READ;
        else if (rx_byte[7:5] == 3'b001) act_d = ACT_WRITE;
        else if (rx_byte == OP_RXLEN)    act_d = ACT_RXLEN;
        else                             act_d = ACT_NONE;
        ftx_d = (rx_byte == OP_FLUSH_TX);
        frx_d = (rx_byte == OP_FLUSH_RX);
      end else begin
        if (act_q == ACT_WRITE && idx_q < cur_len) begin
          if (wide_hit)                  wide_d[wide_id][idx_q] = rx_byte;
          else if (addr_q == REG_STATUS) flags_d = flags_q & ~rx_byte[6:4];
          else                           regs_d[addr_q] = rx_byte;
        end
        if (idx_q != IDX_MAX) idx_d = idx_q + 1'b1;
      end
    end
    // Events take priority over a clearing write in the same cycle.
    flags_d = flags_d | {evt_rx_ready, evt_tx_done, evt_max_retry};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_cmd_q <= 1'b0;
      act_q      <= ACT_NONE;
      addr_q     <= '0;
      idx_q      <= '0;
      flags_q    <= '0;
      flush_tx   <= 1'b0;
      flush_rx   <= 1'b0;
      for (int i = 0; i < REG_COUNT; i++)
        regs_q[i] <= (ADDR_W'(i) == REG_AWIDTH) ? BYTE_W'(3) : '0;
      for (int w = 0; w < NUM_WIDE; w++)
        for (int b = 0; b < ADDR_BYTES_MAX; b++)
          wide_q[w][b] <= '0;
    end else begin
      flags_q  <= flags_d;
      flush_tx <= ftx_d;
      flush_rx <= frx_d;
      if (frame_start || byte_done) begin
        have_cmd_q <= have_cmd_d;
        act_q      <= act_d;
        addr_q     <= addr_d;
        idx_q      <= idx_d;
      end
      if (byte_done) begin
        regs_q <= regs_d;
        wide_q <= wide_d;
      end
    end
  end
endmodule

// File: rtl/spi_cmd_regslave.sv
module spi_cmd_regslave
  import spi_cmdreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sck,
  input  logic              spi_mosi,
  input  logic              spi_cs_n,
  output logic              spi_miso,
  input  logic              evt_rx_ready,
  input  logic              evt_tx_done,
  input  logic              evt_max_retry,
  input  logic [2:0]        rx_pipe_num,
  input  logic              tx_buf_full,
  input  logic [BYTE_W-1:0] rx_head_len,
  output logic              flush_tx,
  output logic              flush_rx
);
  logic              rst_q_n, sel, mosi_s, sck_rise, sck_fall, cs_fall;
  logic              byte_done;
  logic [BYTE_W-1:0] rx_byte, status_byte, next_byte;

  spi_pin_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .sck(spi_sck), .mosi(spi_mosi), .cs_n(spi_cs_n),
    .rst_q_n(rst_q_n), .sel(sel), .mosi_s(mosi_s), .sck_rise(sck_rise),
    .sck_fall(sck_fall), .cs_fall(cs_fall)
  );

  spi_shift_engine u_shift (
    .clk(clk), .rst_n(rst_q_n), .sel(sel), .sck_rise(sck_rise),
    .sck_fall(sck_fall), .cs_fall(cs_fall), .mosi_s(mosi_s),
    .first_byte(status_byte), .next_byte(next_byte),
    .byte_done(byte_done), .rx_byte(rx_byte), .miso(spi_miso)
  );

  spi_cmd_regfile u_regs (
    .clk(clk), .rst_n(rst_q_n), .frame_start(cs_fall), .byte_done(byte_done),
    .rx_byte(rx_byte), .evt_rx_ready(evt_rx_ready), .evt_tx_done(evt_tx_done),
    .evt_max_retry(evt_max_retry), .rx_pipe_num(rx_pipe_num),
    .tx_buf_full(tx_buf_full), .rx_head_len(rx_head_len),
    .status_byte(status_byte), .next_byte(next_byte),
    .flush_tx(flush_tx), .flush_rx(flush_rx)
  );
endmodule

// File: rtl/spi_cmd_regslave_chk.sv
module spi_cmd_regslave_chk (
  input logic clk,
  input logic rst_q_n,
  input logic sel,
  input logic sck_fall,
  input logic cs_fall,
  input logic byte_done,
  input logic miso,
  input logic flush_tx,
  input logic flush_rx,
  input logic rx_flag,
  input logic tx_flag,
  input logic evt_rx,
  input logic evt_tx
);
  assert_miso_moves_on_fall_R1: assert property (@(posedge clk) disable iff (!rst_q_n)
    !$stable(miso) |-> ($past(sck_fall || cs_fall) || $fell(sel)));

  assert_flush_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_q_n)
    $onehot0({flush_tx, flush_rx}));

  assert_flush_single_cycle_R10: assert property (@(posedge clk) disable iff (!rst_q_n)
    (flush_tx || flush_rx) |=> !(flush_tx || flush_rx));

  assert_flush_after_byte_R10: assert property (@(posedge clk) disable iff (!rst_q_n)
    (flush_tx || flush_rx) |-> $past(byte_done));

  assert_rx_flag_needs_event_R6: assert property (@(posedge clk) disable iff (!rst_q_n)
    $rose(rx_flag) |-> $past(evt_rx));

  assert_tx_flag_needs_event_R6: assert property (@(posedge clk) disable iff (!rst_q_n)
    $rose(tx_flag) |-> $past(evt_tx));
endmodule

bind spi_cmd_regslave spi_cmd_regslave_chk u_chk (
  .clk(clk), .rst_q_n(rst_q_n), .sel(sel), .sck_fall(sck_fall), .cs_fall(cs_fall),
  .byte_done(byte_done), .miso(spi_miso), .flush_tx(flush_tx), .flush_rx(flush_rx),
  .rx_flag(status_byte[6]), .tx_flag(status_byte[5]),
  .evt_rx(evt_rx_ready), .evt_tx(evt_tx_done)
);

// File: tb/spi_cmd_regslave_tb.sv
module spi_cmd_regslave_tb;
  localparam int H     = 8;
  localparam int LIMIT = 150000;

  logic clk = 1'b0;
  logic rst_n, sck, mosi, cs_n, miso;
  logic evt_rx, evt_tx, evt_mr, tx_full, flush_tx, flush_rx;
  logic [2:0] rx_pipe;
  logic [7:0] rx_len;

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  int due_tx[$];
  int due_rx[$];

  logic [7:0] mo [16];
  logic [7:0] m_reg [32];
  logic [7:0] m_wide [3][5];
  logic [2:0] m_flags;

  always #10 clk = ~clk;

  spi_cmd_regslave u_dut (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_mosi(mosi), .spi_cs_n(cs_n),
    .spi_miso(miso), .evt_rx_ready(evt_rx), .evt_tx_done(evt_tx),
    .evt_max_retry(evt_mr), .rx_pipe_num(rx_pipe), .tx_buf_full(tx_full),
    .rx_head_len(rx_len), .flush_tx(flush_tx), .flush_rx(flush_rx)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == LIMIT) begin
      checks++;
      fails++;
      $display("FAIL R1 watchdog: cycles %0d expected below %0d", cyc, LIMIT);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  // Per-clock comparison of the flush strobes against the model (R10, R12).
  always @(negedge clk) begin
    if (rst_n) begin
      logic etx, erx;
      while (due_tx.size() > 0 && due_tx[0] < cyc) void'(due_tx.pop_front());
      while (due_rx.size() > 0 && due_rx[0] < cyc) void'(due_rx.pop_front());
      etx = (due_tx.size() > 0 && due_tx[0] == cyc);
      erx = (due_rx.size() > 0 && due_rx[0] == cyc);
      checks++;
      if (flush_tx !== etx || flush_rx !== erx) begin
        fails++;
        $display("FAIL R10 flush at cycle %0d: got tx=%0b rx=%0b expected tx=%0b rx=%0b",
                 cyc, flush_tx, flush_rx, etx, erx);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", tag, got, exp);
    end
  endtask

  function automatic int wide_id(input logic [4:0] a);
    if (a == 5'h0A) return 0;
    if (a == 5'h0B) return 1;
    if (a == 5'h10) return 2;
    return -1;
  endfunction

  function automatic int aw_len();
    case (m_reg[3][1:0])
      2'd2: return 4;
      2'd3: return 5;
      default: return 3;
    endcase
  endfunction

  function automatic logic [7:0] m_status();
    return {1'b0, m_flags, rx_pipe, tx_full};
  endfunction

  function automatic logic [7:0] m_read(input logic [4:0] a, input int k);
    int len;
    len = (wide_id(a) >= 0) ? aw_len() : 1;
    if (k >= len) return 8'h00;
    if (wide_id(a) >= 0) return m_wide[wide_id(a)][k];
    if (a == 5'h07) return m_status();
    return m_reg[a];
  endfunction

  task automatic pulse_evt(input bit r, input bit t, input bit m);
    evt_rx = r; evt_tx = t; evt_mr = m;
    tick(1);
    evt_rx = 0; evt_tx = 0; evt_mr = 0;
    m_flags = m_flags | {r, t, m};
    tick(3);
  endtask

  // One frame: nbytes whole bytes from mo[], then tail_bits of mo[nbytes]
  // before chip select rises.
  task automatic frame(input int nbytes, input int tail_bits, input string tag,
                       input bit set_rx_last = 1'b0);
    int act = 0;   // 0 none, 1 read, 2 write, 3 length query
    logic [4:0] addr = '0;
    cs_n = 0;
    tick(H);
    for (int b = 0; b < nbytes; b++) begin
      logic [7:0] exp, got;
      if (b == 0) exp = m_status();
      else if (act == 1) exp = m_read(addr, b - 1);
      else if (act == 3) exp = (b == 1) ? rx_len : 8'h00;
      else exp = 8'h00;
      for (int i = 7; i >= 0; i--) begin
        mosi = mo[b][i];
        tick(H);
        got[i] = miso;
        sck = 1;
        if (i == 0 && b == 0 && mo[0] == 8'hE1) due_tx.push_back(cyc + 3);
        if (i == 0 && b == 0 && mo[0] == 8'hE2) due_rx.push_back(cyc + 3);
        if (i == 0 && set_rx_last && b == nbytes - 1) begin
          tick(2); evt_rx = 1; tick(1); evt_rx = 0; tick(H - 3);
        end else begin
          tick(H);
        end
        sck = 0;
      end
      chk(got === exp, tag, got, exp);
      if (b == 0) begin
        addr = mo[0][4:0];
        if (mo[0][7:5] == 3'b000) act = 1;
        else if (mo[0][7:5] == 3'b001) act = 2;
        else if (mo[0] == 8'h60) act = 3;
        else act = 0;
      end else if (act == 2) begin
        int len;
        len = (wide_id(addr) >= 0) ? aw_len() : 1;
        if (b - 1 < len) begin
          if (wide_id(addr) >= 0) m_wide[wide_id(addr)][b - 1] = mo[b];
          else if (addr == 5'h07) m_flags = m_flags & ~mo[b][6:4];
          else m_reg[addr] = mo[b];
        end
      end
      if (set_rx_last && b == nbytes - 1) m_flags[2] = 1'b1;
    end
    for (int i = 7; i > 7 - tail_bits; i--) begin
      mosi = mo[nbytes][i];
      tick(H);
      sck = 1;
      tick(H);
      sck = 0;
    end
    tick(H);
    cs_n = 1;
    tick(2 * H);
  endtask

  task automatic set_mo(input logic [7:0] b0, input logic [7:0] b1 = 8'hFF,
                        input logic [7:0] b2 = 8'hFF, input logic [7:0] b3 = 8'hFF,
                        input logic [7:0] b4 = 8'hFF, input logic [7:0] b5 = 8'hFF,
                        input logic [7:0] b6 = 8'hFF);
    mo[0] = b0; mo[1] = b1; mo[2] = b2; mo[3] = b3; mo[4] = b4; mo[5] = b5; mo[6] = b6;
  endtask

  initial begin
    rst_n = 0; sck = 0; mosi = 0; cs_n = 1;
    evt_rx = 0; evt_tx = 0; evt_mr = 0;
    rx_pipe = 3'd7; tx_full = 0; rx_len = 8'h00;
    for (int i = 0; i < 32; i++) m_reg[i] = (i == 3) ? 8'h03 : 8'h00;
    for (int w = 0; w < 3; w++) for (int b = 0; b < 5; b++) m_wide[w][b] = 8'h00;
    m_flags = 3'b000;
    tick(5);
    rst_n = 1;
    tick(6);

    // R13: reset state
    chk(miso === 1'b0, "R13 miso idle after reset", {7'b0, miso}, 8'h00);
    set_mo(8'hFF, 8'hFF);
    frame(2, 0, "R2 nop status and zero fill");
    set_mo(8'h03, 8'hFF, 8'hFF);
    frame(3, 0, "R7 width register reset value");

    // R5 / R4: plain register write and read back
    set_mo(8'h25, 8'h4C, 8'h99, 8'h77);
    frame(4, 0, "R5 write extra bytes dropped");
    set_mo(8'h05, 8'hFF, 8'hFF);
    frame(3, 0, "R4 read back and zero fill");
    set_mo(8'h06, 8'hFF);
    frame(2, 0, "R5 neighbour untouched");

    // R3 / R6: status flags
    pulse_evt(0, 1, 1);
    rx_pipe = 3'd3; tx_full = 1;
    set_mo(8'hFF);
    frame(1, 0, "R3 status layout");
    set_mo(8'h07, 8'hFF);
    frame(2, 0, "R3 status via address 0x07");
    set_mo(8'h27, 8'h20);
    frame(2, 0, "R6 write one clears");
    set_mo(8'h27, 8'h00);
    frame(2, 0, "R6 write zero keeps");
    pulse_evt(1, 0, 0);
    set_mo(8'h27, 8'h50);
    frame(2, 0, "R6 event wins over clear", 1'b1);
    set_mo(8'hFF);
    frame(1, 0, "R6 flag after simultaneous clear");
    set_mo(8'h27, 8'h70);
    frame(2, 0, "R6 clear all");
    rx_pipe = 3'd7; tx_full = 0;

    // R8 / R7: wide address registers
    set_mo(8'h2A, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66);
    frame(7, 0, "R8 five byte write");
    set_mo(8'h0A);
    frame(7, 0, "R8 five byte read lsb first");
    set_mo(8'h23, 8'h01);
    frame(2, 0, "R7 set three byte width");
    set_mo(8'h0A);
    frame(5, 0, "R7 three byte read");
    set_mo(8'h30, 8'hA1, 8'hA2, 8'hA3, 8'hA4, 8'hA5);
    frame(6, 0, "R8 write past width dropped");
    set_mo(8'h23, 8'h02);
    frame(2, 0, "R7 set four byte width");
    set_mo(8'h0A);
    frame(6, 0, "R8 four byte read keeps stored bytes");
    set_mo(8'h23, 8'h03);
    frame(2, 0, "R7 set five byte width");
    set_mo(8'h10);
    frame(7, 0, "R8 transmit address read");
    set_mo(8'h23, 8'h00);
    frame(2, 0, "R7 code zero");
    set_mo(8'h2B, 8'hB1, 8'hB2, 8'hB3, 8'hB4);
    frame(5, 0, "R7 code zero write");
    set_mo(8'h0B);
    frame(5, 0, "R7 code zero gives three bytes");
    set_mo(8'h23, 8'h03);
    frame(2, 0, "R7 restore width");

    // R9: single-byte pipe addresses
    set_mo(8'h2C, 8'h5A, 8'h6B);
    frame(3, 0, "R9 pipe two write");
    set_mo(8'h0C, 8'hFF, 8'hFF);
    frame(3, 0, "R9 pipe two read");
    set_mo(8'h0D, 8'hFF);
    frame(2, 0, "R9 pipe three untouched");

    // R10: flush commands
    set_mo(8'hE1);
    frame(1, 0, "R10 flush transmit");
    set_mo(8'hE2, 8'hFF);
    frame(2, 0, "R10 flush receive");
    set_mo(8'h05, 8'hFF);
    frame(2, 0, "R10 registers kept after flush");

    // R11: head payload length
    rx_len = 8'h1C;
    set_mo(8'h60, 8'hFF, 8'hFF);
    frame(3, 0, "R11 length query");

    // R12: aborted bytes
    set_mo(8'h25, 8'h3C);
    frame(1, 4, "R12 aborted write");
    set_mo(8'h05, 8'hFF);
    frame(2, 0, "R12 register unchanged after abort");
    set_mo(8'hE1);
    frame(0, 6, "R12 aborted flush command");

    // R2: unrecognised command
    set_mo(8'hA0, 8'h12, 8'h34);
    frame(3, 0, "R2 unknown command");
    set_mo(8'h05, 8'hFF);
    frame(2, 0, "R2 no change from unknown command");

    tick(10);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule